// File: doc/BRIEF.md
# SPI Controller with Software Frame Control

This block is a byte-wide SPI shift engine behind a small register port. Software picks the role (bus master or slave), the mode (off, receive-only, transmit-only, full duplex), clock polarity and phase, and whether the data-ready flags raise the interrupt line. It has one transmit buffer and one receive buffer. As master it generates SCK from a programmable half-period divider. As slave it oversamples the external SCK and slave-select inputs.

In master mode, a frame opens when the first byte leaves the transmit buffer. Slave select then stays low across bytes until software tags a byte as the last one. When that tagged byte finishes, the controller releases slave select and clears the tag itself. Software may also take slave select over and drive its level directly.

Error conditions raise the interrupt whatever the data-interrupt enable says: underrun, collision, abort, overrun, and the timer tick of the divider when it runs with the engine off.

Top module: `spic_top`

## Requirements
- R1: Register addresses are 0 control, 1 frame, 2 status, 3 data, 4 divider. Control bits, 7 down to 0: data-irq enable, mode high, timer enable, phase, polarity, wired-or (stored only), master, mode low. Frame bits: 0 end-of-frame tag, 1 manual slave-select level, 2 manual slave-select enable. Status bits: 0 tx empty, 1 rx full, 2 underrun, 3 collision, 4 abort, 5 overrun, 6 timer tick, 7 busy. After reset, control, frame and status read 0x00, slave select is 1 and irq is 0.
- R2: Mode {control[6],control[0]}: 00 is off (no transfer and no SCK activity even with data buffered); 10 is transmit-only (received bytes are not stored, rx full stays 0); 11 is full duplex.
- R3: Mode 01 is receive-only. Status tx empty always reads 0. As slave, every shifted-out bit is 1 and no underrun is reported. As master, no transfer starts.
- R4: As master with automatic select, slave select goes low before the first SCK edge of a frame and stays low between bytes without the tag. After a tagged byte completes, it returns to 1 and the frame tag reads 0.
- R5: With frame bit 2 set, the slave-select output follows frame bit 1 directly.
- R6: With control bit 7 at 0, tx empty and rx full do not drive irq. Setting it makes them drive irq. Error flags drive irq regardless.
- R7: With mode 00 and control bit 5 set, the divider counts (divider value + 1) clocks per tick and sets status bit 6.
- R8: Data moves MSB first. Polarity sets the SCK idle level. Phase 0 samples on the leading edge and phase 1 on the trailing edge. A master loopback returns the sent byte in all four clock modes and divider settings.
- R9: When a byte completes while rx full is set, status overrun sets and the data register keeps the older byte.
- R10: When a slave byte begins its first SCK edge with the transmit buffer empty, status underrun sets and all-ones is sent.
- R11: A data write while the transmit buffer is still full is dropped and sets status collision.
- R12: As slave, if slave select rises after at least one SCK edge of an unfinished byte, status abort sets.
- R13: A data write clears tx empty. A data read clears rx full. Writing 1 to a status bit among 2..6 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects on data register) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| sckIn | input | 1 | SCK from the bus in slave role |
| ssIn | input | 1 | Active-low slave select in slave role |
| sdi | input | 1 | Serial data in |
| sckOut | output | 1 | SCK driven in master role |
| ssOut | output | 1 | Active-low slave select output |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a slave overrun that follows a string of underruns. The transmit buffer must already be drained and the receive buffer left unread while the bench acts as the external master. The bench drives SCK and slave select slowly enough to pass the input synchronizers, captures the serial output bit by bit, and leaves the first byte unread before the next one so that the data register must still hold it. A collision is set up by filling the transmit buffer in receive-only master mode, where nothing ever drains it.

// File: rtl/spic_pkg.sv
package spic_pkg;
  localparam int DATA_W = 8;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_FRAME = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_DATA  = 3'd3;
  localparam logic [2:0] A_DIV   = 3'd4;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RXONLY = 2'b01,
    MODE_TXONLY = 2'b10,
    MODE_DUPLEX = 2'b11
  } modeT;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} stateT;

  typedef struct packed {
    logic txWrite;
    logic loadTx;
    logic loadOnes;
    logic sample;
    logic shift;
    logic rxCapture;
  } dpStrobeT;
endpackage

// File: rtl/spic_dp.sv
module spic_dp
  import spic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] txBuf,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] shreg;
  logic              sampBit;
  logic [DATA_W-1:0] shiftNext;

  assign shiftNext = {shreg[DATA_W-2:0], sampBit};
  assign sdo = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      rxBuf   <= '0;
      shreg   <= '1;
      sampBit <= 1'b1;
    end else begin
      if (strobe.txWrite) txBuf <= wdata;
      if (strobe.sample)  sampBit <= sdi;
      if (strobe.loadTx)        shreg <= txBuf;
      else if (strobe.loadOnes) shreg <= '1;
      else if (strobe.shift)    shreg <= shiftNext;
      if (strobe.rxCapture) rxBuf <= strobe.shift ? shiftNext : shreg;
    end
  end

  // R3 R10: a shift register load is never combined with a shift
  p_load_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadTx, strobe.loadOnes, strobe.shift}) <= 1);
  // R9: the receive buffer only changes on a capture strobe
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rxCapture |=> $stable(rxBuf));
endmodule

// File: rtl/spic_ctrl.sv
module spic_ctrl
  import spic_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [DATA_W-1:0] txBuf,
  input  logic [DATA_W-1:0] rxBuf,
  input  logic              sckIn,
  input  logic              ssIn,
  output dpStrobeT          strobe,
  output logic              sckOut,
  output logic              ssOut,
  output logic              irq
);
  localparam int ERR_N = 5;

  logic [7:0]        ctrlQ;
  logic              eofQ, ssvQ, ssManQ;
  logic [DIV_W-1:0]  divQ, divCntQ;
  logic              txEmptyQ, rxFullQ;
  logic [ERR_N-1:0]  errQ, errSet;
  stateT             stateQ;
  logic [EDGE_W-1:0] edgeCntQ;
  logic              sckLvlQ, frameOnQ, eofLatQ, emptyLoadQ;
  logic [2:0]        sckS;
  logic [1:0]        ssS;

  modeT mode;
  logic dataIrqEn, brgCtl, cpha, cpol, isMaster, enabled, txCapable, storesRx;
  logic wrCtrl, wrFrame, wrStat, wrDiv, wrData, rdData;
  logic acceptTx, collide, divHit, ssLow, sckEdge;
  logic masterStart, slaveStart, haveTx, edgeNow, sampleKind, lastEdge, inDone;
  logic captureOk, slaveAbort, txEmptyVis;
  logic [7:0] statusVec;

  assign dataIrqEn = ctrlQ[7];
  assign mode      = modeT'({ctrlQ[6], ctrlQ[0]});
  assign brgCtl    = ctrlQ[5];
  assign cpha      = ctrlQ[4];
  assign cpol      = ctrlQ[3];
  assign isMaster  = ctrlQ[1];
  assign enabled   = mode != MODE_OFF;
  assign txCapable = mode == MODE_TXONLY || mode == MODE_DUPLEX;
  assign storesRx  = mode == MODE_RXONLY || mode == MODE_DUPLEX;

  assign wrCtrl  = wrEn && addr == A_CTRL;
  assign wrFrame = wrEn && addr == A_FRAME;
  assign wrStat  = wrEn && addr == A_STAT;
  assign wrDiv   = wrEn && addr == A_DIV;
  assign wrData  = wrEn && addr == A_DATA;
  assign rdData  = rdEn && addr == A_DATA;
  assign acceptTx = wrData && txEmptyQ;
  assign collide  = wrData && !txEmptyQ;

  assign divHit  = divCntQ == divQ;
  assign ssLow   = ~ssS[1];
  assign sckEdge = sckS[1] ^ sckS[2];

  assign haveTx      = txCapable && !txEmptyQ;
  assign masterStart = stateQ == ST_IDLE && enabled && isMaster && haveTx;
  assign slaveStart  = stateQ == ST_IDLE && enabled && !isMaster && ssLow;
  assign edgeNow     = stateQ == ST_RUN && (isMaster ? divHit : sckEdge);
  assign sampleKind  = edgeCntQ[0] == cpha;
  assign lastEdge    = edgeCntQ == EDGE_W'(EDGES - 1);
  assign inDone      = stateQ == ST_DONE;
  assign captureOk   = inDone && storesRx && !rxFullQ;
  assign slaveAbort  = stateQ == ST_RUN && !isMaster && !ssLow;

  always_comb begin
    strobe.txWrite   = acceptTx;
    strobe.loadTx    = masterStart || (slaveStart && haveTx);
    strobe.loadOnes  = slaveStart && !haveTx;
    strobe.sample    = edgeNow && sampleKind;
    strobe.shift     = (edgeNow && !sampleKind && edgeCntQ != '0) || (inDone && cpha);
    strobe.rxCapture = captureOk;
  end

  // error flags, status bits 6..2: tick, overrun, abort, collision, underrun
  assign errSet[0] = stateQ == ST_RUN && !isMaster && edgeNow && edgeCntQ == '0 && emptyLoadQ;
  assign errSet[1] = collide;
  assign errSet[2] = slaveAbort && edgeCntQ != '0;
  assign errSet[3] = inDone && storesRx && rxFullQ;
  assign errSet[4] = !enabled && brgCtl && divHit;

  assign txEmptyVis = txEmptyQ && txCapable;
  assign statusVec  = {stateQ != ST_IDLE, errQ, rxFullQ, txEmptyVis};

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrlQ;
      A_FRAME: rdata = {5'b0, ssManQ, ssvQ, eofQ};
      A_STAT:  rdata = statusVec;
      A_DATA:  rdata = rxBuf;
      A_DIV:   rdata = 8'(divQ);
      default: rdata = '0;
    endcase
  end

  assign irq    = (dataIrqEn && enabled && (txEmptyVis || rxFullQ)) || (|errQ);
  assign ssOut  = ssManQ ? ssvQ : ~(frameOnQ && isMaster);
  assign sckOut = isMaster ? (sckLvlQ ^ cpol) : cpol;

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errQ[i] <= 1'b0;
      else       errQ[i] <= errSet[i] | (errQ[i] & ~(wrStat & wdata[i+2]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0; eofQ <= 1'b0; ssvQ <= 1'b0; ssManQ <= 1'b0;
      divQ <= '0; divCntQ <= '0;
      txEmptyQ <= 1'b1; rxFullQ <= 1'b0;
      stateQ <= ST_IDLE; edgeCntQ <= '0;
      sckLvlQ <= 1'b0; frameOnQ <= 1'b0; eofLatQ <= 1'b0; emptyLoadQ <= 1'b0;
      sckS <= '0; ssS <= '1;
    end else begin
      sckS <= {sckS[1:0], sckIn};
      ssS  <= {ssS[0], ssIn};
      if (wrCtrl) ctrlQ <= wdata;
      if (wrDiv)  divQ  <= DIV_W'(wdata);
      if (wrFrame) begin
        eofQ <= wdata[0]; ssvQ <= wdata[1]; ssManQ <= wdata[2];
      end else if (inDone && isMaster && eofLatQ) begin
        eofQ <= 1'b0;
      end

      if (acceptTx)           txEmptyQ <= 1'b0;
      else if (strobe.loadTx) txEmptyQ <= 1'b1;
      if (captureOk)   rxFullQ <= 1'b1;
      else if (rdData) rxFullQ <= 1'b0;

      if ((stateQ == ST_RUN && isMaster) || (!enabled && brgCtl))
        divCntQ <= divHit ? '0 : divCntQ + 1'b1;
      else
        divCntQ <= '0;

      if (stateQ == ST_RUN && isMaster && divHit) sckLvlQ <= ~sckLvlQ;
      else if (stateQ != ST_RUN)                  sckLvlQ <= 1'b0;

      if (!enabled)                  frameOnQ <= 1'b0;
      else if (masterStart)          frameOnQ <= 1'b1;
      else if (inDone && eofLatQ)    frameOnQ <= 1'b0;
      if (masterStart) eofLatQ <= eofQ;
      if (slaveStart)  emptyLoadQ <= !haveTx && txCapable;

      if (masterStart || slaveStart) edgeCntQ <= '0;
      else if (edgeNow)              edgeCntQ <= edgeCntQ + 1'b1;

      if (!enabled) stateQ <= ST_IDLE;
      else begin
        case (stateQ)
          ST_IDLE: if (masterStart || slaveStart) stateQ <= ST_RUN;
          ST_RUN: begin
            if (slaveAbort)             stateQ <= ST_IDLE;
            else if (edgeNow && lastEdge) stateQ <= ST_DONE;
          end
          default: stateQ <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a master in receive-only mode never leaves idle
  p_rxonly_master_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && mode == MODE_RXONLY && stateQ == ST_IDLE) |=> stateQ == ST_IDLE);
  // R4: automatic select is low whenever a master byte is shifting
  p_ss_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !ssManQ && stateQ == ST_RUN) |-> !ssOut);
  // R4: the end tag is gone after a tagged byte completes
  p_eof_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inDone && isMaster && eofLatQ && !wrFrame) |=> !eofQ);
  // R9: completion with rx full raises overrun
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inDone && storesRx && rxFullQ) |=> errQ[3]);
  // R6: no errors and data irq disabled keeps irq low
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dataIrqEn && errQ == '0) |-> !irq);
  // R8: the master SCK rests at the polarity level outside a byte
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && stateQ != ST_RUN) |-> sckOut == cpol);
endmodule

// File: rtl/spic_top.sv
module spic_top
  import spic_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sckIn,
  input  logic       ssIn,
  input  logic       sdi,
  output logic       sckOut,
  output logic       ssOut,
  output logic       sdo,
  output logic       irq
);
  dpStrobeT          strobe;
  logic [DATA_W-1:0] txBuf, rxBuf;

  spic_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txBuf(txBuf), .rxBuf(rxBuf),
    .sckIn(sckIn), .ssIn(ssIn), .strobe(strobe), .sckOut(sckOut),
    .ssOut(ssOut), .irq(irq)
  );

  spic_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(wdata[DATA_W-1:0]),
    .sdi(sdi), .sdo(sdo), .txBuf(txBuf), .rxBuf(rxBuf)
  );
endmodule

// File: tb/spic_top_tb_top.sv
module spic_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sckIn = 1'b0, ssIn = 1'b1, slvSdi = 1'b0, loopEn = 1'b1;
  logic sdi, sckOut, ssOut, sdo, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign sdi = loopEn ? sdo : slvSdi;

  spic_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sckIn(sckIn), .ssIn(ssIn), .sdi(sdi),
    .sckOut(sckOut), .ssOut(ssOut), .sdo(sdo), .irq(irq)
  );

  // {control, tx byte, divider}: master full duplex loopback
  localparam logic [23:0] VEC [8] = '{
    {8'h43, 8'hA5, 8'd1}, {8'h43, 8'h0F, 8'd0}, {8'h53, 8'h3C, 8'd1},
    {8'h53, 8'h81, 8'd2}, {8'h4B, 8'h7E, 8'd1}, {8'h4B, 8'h00, 8'd0},
    {8'h5B, 8'hFF, 8'd1}, {8'h5B, 8'h96, 8'd3}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // bench acts as a mode-0 master toward the slave
  task automatic slave_byte(input logic [7:0] pat, output logic [7:0] got);
    ssIn = 1'b0; wait_cyc(8);
    for (int i = 7; i >= 0; i--) begin
      slvSdi = pat[i]; wait_cyc(4);
      got[i] = sdo;
      sckIn = 1'b1; wait_cyc(6);
      sckIn = 1'b0; wait_cyc(6);
    end
    wait_cyc(6); ssIn = 1'b1; wait_cyc(6);
  endtask

  initial begin
    logic [7:0] v, got;
    wait_cyc(3);
    // R1: reset state
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd1, v); chk("R1 frame", v, 8'h00);
    rd(3'd2, v); chk("R1 status", v, 8'h00);
    chk("R1 ss", {7'b0, ssOut}, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rstN = 1'b1; wait_cyc(2);

    // R8 R4: loopback in all clock modes, each byte tagged as frame end
    for (int k = 0; k < 8; k++) begin
      wr(3'd4, VEC[k][7:0]);
      wr(3'd0, VEC[k][23:16]);
      wr(3'd1, 8'h01);
      wr(3'd3, VEC[k][15:8]);
      wait_cyc(16 * (int'(VEC[k][7:0]) + 1) + 20);
      chk("R4 ss released", {7'b0, ssOut}, 8'h01);
      chk("R8 sck idle", {7'b0, sckOut}, {7'b0, VEC[k][19]});
      rd(3'd1, v); chk("R4 tag cleared", v, 8'h00);
      rd(3'd3, v); chk("R8 loopback", v, VEC[k][15:8]);
    end

    // R4: select held between untagged bytes
    wr(3'd4, 8'd1); wr(3'd0, 8'h43); wr(3'd1, 8'h00);
    wr(3'd3, 8'h12); wait_cyc(60);
    chk("R4 ss held", {7'b0, ssOut}, 8'h00);
    rd(3'd3, v); chk("R4 byte1", v, 8'h12);
    wr(3'd1, 8'h01); wr(3'd3, 8'h34); wait_cyc(60);
    chk("R4 ss end", {7'b0, ssOut}, 8'h01);
    rd(3'd3, v); chk("R4 byte2", v, 8'h34);

    // R5: manual select
    wr(3'd1, 8'h04); wait_cyc(1); chk("R5 manual low", {7'b0, ssOut}, 8'h00);
    wr(3'd1, 8'h06); wait_cyc(1); chk("R5 manual high", {7'b0, ssOut}, 8'h01);
    wr(3'd1, 8'h00);

    // R2: transmit-only stores nothing
    wr(3'd0, 8'h42); wr(3'd1, 8'h01); wr(3'd3, 8'h5A); wait_cyc(60);
    rd(3'd2, v); chk("R2 txonly status", v, 8'h01);
    chk("R2 txonly ss", {7'b0, ssOut}, 8'h01);

    // R3: receive-only master never starts, tx empty hidden
    wr(3'd0, 8'h03); wr(3'd3, 8'h77); wait_cyc(60);
    rd(3'd2, v); chk("R3 master rxonly status", v, 8'h00);
    chk("R3 master rxonly ss", {7'b0, ssOut}, 8'h01);

    // R11 R6 R13: collision while buffer full
    wr(3'd3, 8'h88); wait_cyc(1);
    rd(3'd2, v); chk("R11 collision", v, 8'h08);
    chk("R6 error irq", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h08); wait_cyc(1);
    rd(3'd2, v); chk("R13 w1c", v, 8'h00);
    chk("R13 irq cleared", {7'b0, irq}, 8'h00);

    // R2: mode off with buffered data does nothing
    wr(3'd0, 8'h02); wait_cyc(60);
    rd(3'd2, v); chk("R2 off status", v, 8'h00);
    chk("R2 off ss", {7'b0, ssOut}, 8'h01);
    chk("R2 off sck", {7'b0, sckOut}, 8'h00);

    // R7: timer tick
    wr(3'd4, 8'd3); wr(3'd0, 8'h20); wait_cyc(10);
    rd(3'd2, v); chk("R7 tick", v, 8'h40);
    chk("R7 irq", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h00); wr(3'd2, 8'h40); wait_cyc(20);
    rd(3'd2, v); chk("R7 tick cleared", v, 8'h00);

    // slave role, mode 0: buffered 0x77 goes out, 0xC3 comes in
    loopEn = 1'b0;
    wr(3'd0, 8'h41);
    slave_byte(8'hC3, got);
    chk("R8 slave msb-first tx", got, 8'h77);
    rd(3'd2, v); chk("R13 rx full", v, 8'h03);
    chk("R6 data irq masked", {7'b0, irq}, 8'h00);
    wr(3'd0, 8'hC1); wait_cyc(1);
    chk("R6 data irq enabled", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h41);
    rd(3'd3, v); chk("R8 slave rx", v, 8'hC3);
    rd(3'd2, v); chk("R13 rx read clears", v, 8'h01);

    // R10: underrun with empty buffer
    slave_byte(8'h3C, got);
    chk("R10 ones out", got, 8'hFF);
    rd(3'd2, v); chk("R10 underrun", v, 8'h07);
    rd(3'd3, v); chk("R10 rx", v, 8'h3C);

    // R9: overrun keeps first byte
    slave_byte(8'h99, got);
    slave_byte(8'h66, got);
    rd(3'd2, v); chk("R9 overrun", v & 8'h20, 8'h20);
    rd(3'd3, v); chk("R9 old byte kept", v, 8'h99);
    wr(3'd2, 8'hFC);

    // R12: abort after three edges
    ssIn = 1'b0; wait_cyc(8);
    sckIn = 1'b1; wait_cyc(6); sckIn = 1'b0; wait_cyc(6);
    sckIn = 1'b1; wait_cyc(6); ssIn = 1'b1; wait_cyc(6);
    sckIn = 1'b0; wait_cyc(6);
    rd(3'd2, v); chk("R12 abort", v & 8'h10, 8'h10);
    wr(3'd2, 8'hFC);

    // R3: receive-only slave
    wr(3'd0, 8'h01); wr(3'd3, 8'h42);
    rd(3'd2, v); chk("R3 txe hidden", v, 8'h00);
    slave_byte(8'h5F, got);
    chk("R3 slave ones", got, 8'hFF);
    rd(3'd2, v); chk("R3 no underrun", v, 8'h02);
    rd(3'd3, v); chk("R3 rx", v, 8'h5F);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule